// File: doc/BRIEF.md
# Chain Tag Sequencer

The sequencer drives one source-chain channel of a memory-to-peripheral mover. It is started with the byte address of a first 64-bit tag. It fetches that tag through a request/acknowledge port, decodes it, and issues at most one data-transfer request (a start address and a count of 16-byte quadwords) to an external data mover. It then works out where the next tag lives and repeats until a tag ends the chain. Memory and the data mover sit outside the block.

A tag carries its command in bits 31:0 and an address in bits 63:32. The command holds an interrupt-request bit, a three-bit kind, two priority bits that pass unused, and a 16-bit quadword count. Some kinds stream the quadwords that sit directly behind the tag. Others stream from the tag's address field. The kind also picks the next tag: right after the data, right after the tag, at the address field, or at an address saved earlier on a two-entry return stack by a call-style tag. When the chain finishes, the block pulses `done_o` for one cycle. On that same cycle `err_o` reports an illegal chain and `irq_o` reports a stop requested by a tag.

The control is one state machine. ST_IDLE waits for `start_i`: it goes to ST_FETCH for an aligned start address and to ST_FINISH for a misaligned one. ST_FETCH holds the tag request and moves to ST_DECODE on `tag_ack_i`. ST_DECODE goes to ST_FINISH on an error, to ST_XFER when the count is nonzero, and to ST_ADVANCE otherwise. ST_XFER holds the transfer request and moves to ST_ADVANCE on `xfer_ack_i`. ST_ADVANCE goes to ST_FINISH when the chain stops and back to ST_FETCH otherwise. ST_FINISH always returns to ST_IDLE.

Top module: `chain_tag_seq`

## Requirements
- R1: After reset, and whenever ST_IDLE is left by `start_i` with an aligned start address, the first tag request is for that address. Out of reset no request, `done_o`, `err_o` or `irq_o` is active and the stack depth reads 0. `tag_addr_o` holds steady while `tag_req_o` waits for `tag_ack_i`.
- R2: Kind 1 (count) transfers its count from the tag address plus 16. The next tag is at tag address + 16 + 16 × count.
- R3: Kind 2 (next) transfers its count from the tag address plus 16. The next tag is at the tag's address field.
- R4: Kinds 3 and 4 (reference, reference-with-stall) transfer their count from the address field. The next tag is at the tag address plus 16.
- R5: Kind 5 (call) transfers like kind 2, pushes tag address + 16 + 16 × count, and continues at the address field. Kind 6 (return) transfers from behind the tag and continues at the popped address. `stack_depth_o` reports 0, 1 or 2 entries.
- R6: Kind 6 with an empty stack transfers its data and then ends the chain without error.
- R7: Kind 7 (end) transfers from behind the tag, and kind 0 (reference-and-end) transfers from the address field. Either one then ends the chain with `done_o` high and `err_o` low.
- R8: Kind 5 met while two entries are already pushed ends the chain with `err_o` set on the `done_o` cycle, and issues no transfer for that tag.
- R9: A misaligned start address (bits 3:0 nonzero) ends the chain with an error before any fetch. A kind that uses its address field (0, 2, 3, 4, 5) with a misaligned address field ends the chain with an error and no transfer for that tag.
- R10: Tag bit 31 with `tag_irq_en_i` high ends the chain after that tag's transfer, with `irq_o` high on the `done_o` cycle. With `tag_irq_en_i` low the bit has no effect.
- R11: A tag whose count (bits 15:0) is zero raises no transfer request.
- R12: `xfer_req_o` stays high, with `xfer_addr_o` and `xfer_qwc_o` unchanged, until `xfer_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a chain when idle |
| chain_addr_i | input | 32 | Byte address of the first tag |
| tag_irq_en_i | input | 1 | Lets a tag's interrupt bit stop the chain |
| tag_req_o | output | 1 | Tag fetch request |
| tag_addr_o | output | 32 | Byte address of the tag being fetched |
| tag_ack_i | input | 1 | Tag fetch acknowledge, `tag_data_i` valid |
| tag_data_i | input | 64 | Fetched tag |
| xfer_req_o | output | 1 | Data transfer request |
| xfer_addr_o | output | 32 | Transfer start byte address |
| xfer_qwc_o | output | 16 | Transfer length in quadwords |
| xfer_ack_i | input | 1 | Transfer complete |
| done_o | output | 1 | One-cycle end-of-chain pulse |
| err_o | output | 1 | Chain ended on an error (valid with `done_o`) |
| irq_o | output | 1 | Chain ended on a tag interrupt (valid with `done_o`) |
| stack_depth_o | output | 2 | Entries on the return stack |

## Verification
Directed chains each isolate one tag kind, so that a wrong next-address choice shows up as a wrong fetch address and a wrong data source as a wrong transfer address. Nested calls separate correct last-in-first-out return order from a stack that drops or reorders entries, and a third nested call exercises the overflow error. Zero counts, misaligned addresses and the interrupt bit with the enable on and off isolate the stop and error paths. Random tag memories, with random acknowledge delays, mix all kinds into long chains and compare the full fetch and transfer sequence against a model of the requirements.

// File: rtl/chain_seq_pkg.sv
`timescale 1ns/1ps
package chain_seq_pkg;

    localparam int ADDR_W   = 32;
    localparam int QWC_W    = 16;
    localparam int TAG_W    = 64;
    localparam int QW_SHIFT = 4;   // 16-byte quadword

    typedef enum logic [2:0] {
        TID_REFE = 3'd0,
        TID_CNT  = 3'd1,
        TID_NEXT = 3'd2,
        TID_REF  = 3'd3,
        TID_REFS = 3'd4,
        TID_CALL = 3'd5,
        TID_RET  = 3'd6,
        TID_END  = 3'd7
    } tag_id_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_XFER,
        ST_ADVANCE,
        ST_FINISH
    } seq_state_e;

    typedef struct packed {
        logic        irq;
        tag_id_e     id;
        logic [1:0]  prio;
        logic [9:0]  rsvd;
        logic [15:0] qwc;
    } cmd_word_t;

    function automatic logic uses_addr_field(tag_id_e id);
        return (id == TID_REFE) || (id == TID_NEXT) || (id == TID_REF) ||
               (id == TID_REFS) || (id == TID_CALL);
    endfunction

    function automatic logic sources_from_field(tag_id_e id);
        return (id == TID_REFE) || (id == TID_REF) || (id == TID_REFS);
    endfunction

endpackage

// File: rtl/chain_ret_stack.sv
`timescale 1ns/1ps
module chain_ret_stack #(
    parameter int DEPTH = 2,
    parameter int AW    = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [AW-1:0] push_data_i,
    output logic [AW-1:0] top_o,
    output logic          empty_o,
    output logic          full_o,
    output logic [CW-1:0] count_o
);

    logic [CW-1:0]             count_q;
    logic [DEPTH-1:0][AW-1:0]  slot_w;

    assign empty_o = (count_q == '0);
    assign full_o  = (count_q == CW'(DEPTH));
    assign count_o = count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear_i) begin
            count_q <= '0;
        end else if (push_i && !full_o) begin
            count_q <= count_q + 1'b1;
        end else if (pop_i && !empty_o) begin
            count_q <= count_q - 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [AW-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (push_i && !full_o && !clear_i && (count_q == CW'(g))) begin
                slot_q <= push_data_i;
            end
        end
        assign slot_w[g] = slot_q;
    end

    always_comb begin
        top_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (count_q == CW'(i + 1)) begin
                top_o = slot_w[i];
            end
        end
    end

endmodule

// File: rtl/chain_tag_decode.sv
`timescale 1ns/1ps
module chain_tag_decode
    import chain_seq_pkg::*;
(
    input  logic [TAG_W-1:0]  tag_i,
    input  logic [ADDR_W-1:0] tag_base_i,
    input  logic              irq_en_i,
    input  logic              stk_empty_i,
    input  logic              stk_full_i,
    input  logic [ADDR_W-1:0] stk_top_i,
    output logic [QWC_W-1:0]  qwc_o,
    output logic [ADDR_W-1:0] xfer_addr_o,
    output logic [ADDR_W-1:0] next_addr_o,
    output logic [ADDR_W-1:0] ret_addr_o,
    output logic              push_o,
    output logic              pop_o,
    output logic              stop_o,
    output logic              irq_o,
    output logic              err_o
);

    cmd_word_t         cmd;
    logic [ADDR_W-1:0] field_addr;
    logic [ADDR_W-1:0] body_addr;
    logic [ADDR_W-1:0] after_addr;
    logic              field_bad;
    logic              unused_cmd_bits;

    assign cmd             = cmd_word_t'(tag_i[31:0]);
    assign field_addr      = tag_i[63:32];
    assign unused_cmd_bits = ^{cmd.prio, cmd.rsvd};

    assign body_addr  = tag_base_i + ADDR_W'(1 << QW_SHIFT);
    assign after_addr = body_addr + (ADDR_W'(cmd.qwc) << QW_SHIFT);
    assign field_bad  = uses_addr_field(cmd.id) && (field_addr[QW_SHIFT-1:0] != '0);

    assign qwc_o       = cmd.qwc;
    assign ret_addr_o  = after_addr;
    assign xfer_addr_o = sources_from_field(cmd.id) ? field_addr : body_addr;
    assign err_o       = field_bad || ((cmd.id == TID_CALL) && stk_full_i);
    assign irq_o       = cmd.irq && irq_en_i;
    assign push_o      = (cmd.id == TID_CALL);
    assign pop_o       = (cmd.id == TID_RET) && !stk_empty_i;

    always_comb begin
        next_addr_o = body_addr;
        stop_o      = 1'b0;
        unique case (cmd.id)
            TID_CNT:            next_addr_o = after_addr;
            TID_NEXT, TID_CALL: next_addr_o = field_addr;
            TID_REF, TID_REFS:  next_addr_o = body_addr;
            TID_RET: begin
                next_addr_o = stk_top_i;
                stop_o      = stk_empty_i;
            end
            TID_REFE, TID_END:  stop_o = 1'b1;
            default:            stop_o = 1'b1;
        endcase
        if (irq_o) begin
            stop_o = 1'b1;
        end
    end

endmodule

// File: rtl/chain_tag_seq.sv
`timescale 1ns/1ps
module chain_tag_seq
    import chain_seq_pkg::*;
#(
    parameter int  STACK_DEPTH = 2,
    localparam int SPW         = $clog2(STACK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] chain_addr_i,
    input  logic              tag_irq_en_i,
    output logic              tag_req_o,
    output logic [ADDR_W-1:0] tag_addr_o,
    input  logic              tag_ack_i,
    input  logic [TAG_W-1:0]  tag_data_i,
    output logic              xfer_req_o,
    output logic [ADDR_W-1:0] xfer_addr_o,
    output logic [QWC_W-1:0]  xfer_qwc_o,
    input  logic              xfer_ack_i,
    output logic              done_o,
    output logic              err_o,
    output logic              irq_o,
    output logic [SPW-1:0]    stack_depth_o
);

    seq_state_e        state_q, state_d;

    logic [ADDR_W-1:0] cur_addr_q;
    logic [TAG_W-1:0]  tag_q;
    logic [ADDR_W-1:0] xaddr_q;
    logic [QWC_W-1:0]  xqwc_q;
    logic [ADDR_W-1:0] next_q;
    logic              stop_q;
    logic              irq_q;
    logic              err_q;

    logic [QWC_W-1:0]  dec_qwc;
    logic [ADDR_W-1:0] dec_xaddr;
    logic [ADDR_W-1:0] dec_next;
    logic [ADDR_W-1:0] dec_ret;
    logic              dec_push, dec_pop, dec_stop, dec_irq, dec_err;

    logic              stk_clear, stk_push, stk_pop;
    logic              stk_empty, stk_full;
    logic [ADDR_W-1:0] stk_top;
    logic              start_bad;

    assign start_bad = (chain_addr_i[QW_SHIFT-1:0] != '0);

    chain_tag_decode u_decode (
        .tag_i       (tag_q),
        .tag_base_i  (cur_addr_q),
        .irq_en_i    (tag_irq_en_i),
        .stk_empty_i (stk_empty),
        .stk_full_i  (stk_full),
        .stk_top_i   (stk_top),
        .qwc_o       (dec_qwc),
        .xfer_addr_o (dec_xaddr),
        .next_addr_o (dec_next),
        .ret_addr_o  (dec_ret),
        .push_o      (dec_push),
        .pop_o       (dec_pop),
        .stop_o      (dec_stop),
        .irq_o       (dec_irq),
        .err_o       (dec_err)
    );

    assign stk_clear = (state_q == ST_IDLE) && start_i;
    assign stk_push  = (state_q == ST_DECODE) && dec_push && !dec_err;
    assign stk_pop   = (state_q == ST_DECODE) && dec_pop && !dec_err;

    chain_ret_stack #(
        .DEPTH (STACK_DEPTH),
        .AW    (ADDR_W)
    ) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (stk_clear),
        .push_i      (stk_push),
        .pop_i       (stk_pop),
        .push_data_i (dec_ret),
        .top_o       (stk_top),
        .empty_o     (stk_empty),
        .full_o      (stk_full),
        .count_o     (stack_depth_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i)    state_d = start_bad ? ST_FINISH : ST_FETCH;
            ST_FETCH:   if (tag_ack_i)  state_d = ST_DECODE;
            ST_DECODE: begin
                if (dec_err)              state_d = ST_FINISH;
                else if (dec_qwc != '0)   state_d = ST_XFER;
                else                      state_d = ST_ADVANCE;
            end
            ST_XFER:    if (xfer_ack_i) state_d = ST_ADVANCE;
            ST_ADVANCE:                 state_d = stop_q ? ST_FINISH : ST_FETCH;
            ST_FINISH:                  state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr_q <= '0;
            tag_q      <= '0;
            xaddr_q    <= '0;
            xqwc_q     <= '0;
            next_q     <= '0;
            stop_q     <= 1'b0;
            irq_q      <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        cur_addr_q <= chain_addr_i;
                        err_q      <= start_bad;
                        irq_q      <= 1'b0;
                        stop_q     <= 1'b0;
                    end
                end
                ST_FETCH: begin
                    if (tag_ack_i) begin
                        tag_q <= tag_data_i;
                    end
                end
                ST_DECODE: begin
                    xaddr_q <= dec_xaddr;
                    xqwc_q  <= dec_qwc;
                    next_q  <= dec_next;
                    stop_q  <= dec_stop;
                    irq_q   <= dec_irq && !dec_err;
                    err_q   <= dec_err;
                end
                ST_ADVANCE: begin
                    if (!stop_q) begin
                        cur_addr_q <= next_q;
                    end
                end
                ST_XFER, ST_FINISH: begin
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        tag_req_o   = 1'b0;
        xfer_req_o  = 1'b0;
        done_o      = 1'b0;
        err_o       = 1'b0;
        irq_o       = 1'b0;
        tag_addr_o  = cur_addr_q;
        xfer_addr_o = xaddr_q;
        xfer_qwc_o  = xqwc_q;
        unique case (state_q)
            ST_FETCH:  tag_req_o  = 1'b1;
            ST_XFER:   xfer_req_o = 1'b1;
            ST_FINISH: begin
                done_o = 1'b1;
                err_o  = err_q;
                irq_o  = irq_q;
            end
            ST_IDLE, ST_DECODE, ST_ADVANCE: begin
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/chain_tag_seq_chk.sv
`timescale 1ns/1ps
module chain_tag_seq_chk #(
    parameter int SPW = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tag_req_o,
    input logic           tag_ack_i,
    input logic [31:0]    tag_addr_o,
    input logic           xfer_req_o,
    input logic           xfer_ack_i,
    input logic [31:0]    xfer_addr_o,
    input logic [15:0]    xfer_qwc_o,
    input logic           done_o,
    input logic           err_o,
    input logic           irq_o,
    input logic [SPW-1:0] stack_depth_o
);

    p_tag_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_req_o && !tag_ack_i) |=> (tag_req_o && $stable(tag_addr_o)));

    p_xfer_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req_o && !xfer_ack_i) |=>
            (xfer_req_o && $stable(xfer_addr_o) && $stable(xfer_qwc_o)));

    p_depth_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stack_depth_o <= SPW'(2));

    p_irq_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> done_o);

    p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    p_nonzero_xfer_r11: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |-> (xfer_qwc_o != 16'd0));

    p_aligned_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |-> (xfer_addr_o[3:0] == 4'd0));

    p_one_port_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(tag_req_o && xfer_req_o));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

bind chain_tag_seq chain_tag_seq_chk #(.SPW(SPW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tag_req_o     (tag_req_o),
    .tag_ack_i     (tag_ack_i),
    .tag_addr_o    (tag_addr_o),
    .xfer_req_o    (xfer_req_o),
    .xfer_ack_i    (xfer_ack_i),
    .xfer_addr_o   (xfer_addr_o),
    .xfer_qwc_o    (xfer_qwc_o),
    .done_o        (done_o),
    .err_o         (err_o),
    .irq_o         (irq_o),
    .stack_depth_o (stack_depth_o)
);

// File: tb/chain_tag_seq_bench.sv
`timescale 1ns/1ps
module chain_tag_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] chain_addr_i = '0;
    logic        tag_irq_en_i = 1'b0;
    logic        tag_req_o;
    logic [31:0] tag_addr_o;
    logic        tag_ack_i = 1'b0;
    logic [63:0] tag_data_i = '0;
    logic        xfer_req_o;
    logic [31:0] xfer_addr_o;
    logic [15:0] xfer_qwc_o;
    logic        xfer_ack_i = 1'b0;
    logic        done_o, err_o, irq_o;
    logic [1:0]  stack_depth_o;

    always #10 clk = ~clk;   // 50 MHz

    chain_tag_seq u_chain_tag_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chain_addr_i(chain_addr_i),
        .tag_irq_en_i(tag_irq_en_i), .tag_req_o(tag_req_o), .tag_addr_o(tag_addr_o),
        .tag_ack_i(tag_ack_i), .tag_data_i(tag_data_i), .xfer_req_o(xfer_req_o),
        .xfer_addr_o(xfer_addr_o), .xfer_qwc_o(xfer_qwc_o), .xfer_ack_i(xfer_ack_i),
        .done_o(done_o), .err_o(err_o), .irq_o(irq_o), .stack_depth_o(stack_depth_o)
    );

    logic [63:0] mem [1024];
    logic [31:0] exp_f[$], obs_f[$];
    logic [47:0] exp_x[$], obs_x[$];
    logic        exp_err, exp_irq, got_err, got_irq;
    bit          fin;
    int          max_depth;
    int          n_checks = 0;
    int          n_fail = 0;
    int          tdly = 0;
    int          xdly = 0;
    bit          xseen = 0;
    logic [31:0] xa0;
    logic [15:0] xq0;

    function automatic logic [63:0] mk(input int id, input int q, input logic [31:0] a, input bit ir);
        return {a, ir, 3'(id), 2'b00, 10'd0, 16'(q)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = 64'd0;
    endtask

    // expected chain walk, from the requirements
    task automatic model(input logic [31:0] s, input logic tie, output bit ok);
        logic [31:0] t, nt, a, body, after, xa;
        logic [31:0] stk [2];
        logic [63:0] tg;
        logic [15:0] q;
        int          id, d;
        bit          stop, usea;
        exp_f.delete(); exp_x.delete();
        exp_err = 0; exp_irq = 0; ok = 1; d = 0;
        if (s[3:0] != 0) begin exp_err = 1; return; end
        t = s;
        for (int n = 0; ; n++) begin
            if (n >= 40) begin ok = 0; return; end
            exp_f.push_back(t);
            tg = mem[t[13:4]];
            id = int'(tg[30:28]); q = tg[15:0]; a = tg[63:32];
            usea = (id == 0 || id == 2 || id == 3 || id == 4 || id == 5);
            if ((usea && a[3:0] != 0) || (id == 5 && d == 2)) begin exp_err = 1; return; end
            body  = t + 32'd16;
            after = body + (32'(q) << 4);
            xa = (id == 0 || id == 3 || id == 4) ? a : body;
            if (q != 0) exp_x.push_back({xa, q});
            stop = 0; nt = body;
            case (id)
                0, 7: stop = 1;
                1: nt = after;
                2: nt = a;
                3, 4: nt = body;
                5: begin stk[d] = after; d++; nt = a; end
                default: if (d > 0) begin d--; nt = stk[d]; end else stop = 1;
            endcase
            if (tg[31] && tie) begin exp_irq = 1; stop = 1; end
            if (stop) return;
            t = nt;
        end
    endtask

    // memory and data-mover responder, driven away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (tag_ack_i) tag_ack_i = 1'b0;
            else if (tag_req_o) begin
                if (tdly == 0) begin
                    tag_ack_i  = 1'b1;
                    tag_data_i = mem[tag_addr_o[13:4]];
                    obs_f.push_back(tag_addr_o);
                    tdly = int'($urandom % 3);
                end else tdly--;
            end
            if (xfer_ack_i) xfer_ack_i = 1'b0;
            else if (xfer_req_o) begin
                if (!xseen) begin xseen = 1; xa0 = xfer_addr_o; xq0 = xfer_qwc_o; end
                if (xdly == 0) begin
                    chk(xa0 == xfer_addr_o && xq0 == xfer_qwc_o, "R12", "request held",
                        {xfer_addr_o, xfer_qwc_o}, {xa0, xq0});
                    xfer_ack_i = 1'b1;
                    obs_x.push_back({xfer_addr_o, xfer_qwc_o});
                    xseen = 0;
                    xdly = int'($urandom % 4);
                end else xdly--;
            end
            if (int'(stack_depth_o) > max_depth) max_depth = int'(stack_depth_o);
            if (done_o) begin fin = 1; got_err = err_o; got_irq = irq_o; end
        end
    end

    task automatic run_chain(input logic [31:0] s, input logic tie, input string req);
        bit ok;
        model(s, tie, ok);
        obs_f.delete(); obs_x.delete();
        fin = 0; max_depth = 0;
        @(negedge clk);
        start_i = 1'b1; chain_addr_i = s; tag_irq_en_i = tie;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c < 5000 && !fin; c++) @(negedge clk);
        chk(fin, req, "done reached", longint'(fin), 1);
        chk(obs_f.size() == exp_f.size(), req, "tag fetch count", obs_f.size(), exp_f.size());
        if (obs_f.size() == exp_f.size())
            for (int i = 0; i < obs_f.size(); i++)
                chk(obs_f[i] == exp_f[i], req, "tag fetch address", obs_f[i], exp_f[i]);
        chk(obs_x.size() == exp_x.size(), req, "transfer count", obs_x.size(), exp_x.size());
        if (obs_x.size() == exp_x.size())
            for (int i = 0; i < obs_x.size(); i++)
                chk(obs_x[i] == exp_x[i], req, "transfer addr/qwc", obs_x[i], exp_x[i]);
        chk(got_err == exp_err, req, "error flag", got_err, exp_err);
        chk(got_irq == exp_irq, req, "interrupt flag", got_irq, exp_irq);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        bit ok;
        void'($urandom(32'd20240611));
        clear_mem();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!tag_req_o && !xfer_req_o && !done_o && !err_o && !irq_o, "R1", "idle outputs in reset",
            {tag_req_o, xfer_req_o, done_o, err_o, irq_o}, 0);
        chk(stack_depth_o == 2'd0, "R1", "stack depth in reset", stack_depth_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tag_req_o && !done_o, "R1", "idle after reset", {tag_req_o, done_o}, 0);

        // R2, R7: count then end
        mem[16'h100 >> 4] = mk(1, 2, 32'h0, 0);
        mem[16'h130 >> 4] = mk(7, 1, 32'h0, 0);
        run_chain(32'h100, 1'b0, "R2");
        chk(exp_x.size() == 2 && obs_x.size() > 1 && obs_x[1] == {32'h140, 16'd1},
            "R7", "end streams behind tag", obs_x.size() > 1 ? obs_x[1] : 0, {32'h140, 16'd1});

        // R3, R7: next then reference-and-end
        clear_mem();
        mem[16'h200 >> 4] = mk(2, 1, 32'h400, 0);
        mem[16'h400 >> 4] = mk(0, 3, 32'h800, 0);
        run_chain(32'h200, 1'b0, "R3");

        // R4, R11: reference, stall-reference, zero-count end
        clear_mem();
        mem[16'h300 >> 4] = mk(3, 2, 32'h900, 0);
        mem[16'h310 >> 4] = mk(4, 1, 32'hA00, 0);
        mem[16'h320 >> 4] = mk(7, 0, 32'h0, 0);
        run_chain(32'h300, 1'b0, "R4");
        chk(obs_x.size() == 2, "R11", "zero count raises no transfer", obs_x.size(), 2);

        // R5: nested call and return
        clear_mem();
        mem[16'h000 >> 4] = mk(5, 1, 32'h500, 0);
        mem[16'h500 >> 4] = mk(5, 0, 32'h600, 0);
        mem[16'h600 >> 4] = mk(6, 1, 32'h0, 0);
        mem[16'h510 >> 4] = mk(6, 0, 32'h0, 0);
        mem[16'h020 >> 4] = mk(7, 0, 32'h0, 0);
        run_chain(32'h000, 1'b0, "R5");
        chk(max_depth == 2, "R5", "stack reaches two entries", max_depth, 2);

        // R6: return with empty stack
        clear_mem();
        mem[16'h700 >> 4] = mk(6, 2, 32'h0, 0);
        run_chain(32'h700, 1'b0, "R6");

        // R8: third nested call overflows
        clear_mem();
        mem[16'h1000 >> 4] = mk(5, 0, 32'h1100, 0);
        mem[16'h1100 >> 4] = mk(5, 0, 32'h1200, 0);
        mem[16'h1200 >> 4] = mk(5, 1, 32'h1300, 0);
        run_chain(32'h1000, 1'b0, "R8");
        chk(got_err && obs_x.size() == 0, "R8", "overflow error, no transfer", {got_err, 8'(obs_x.size())}, 9'h100);

        // R9: misaligned start and misaligned field
        clear_mem();
        run_chain(32'h104, 1'b0, "R9");
        chk(obs_f.size() == 0, "R9", "no fetch for bad start", obs_f.size(), 0);
        mem[16'h140 >> 4] = mk(3, 2, 32'h908, 0);
        run_chain(32'h140, 1'b0, "R9");

        // R10: interrupt bit with enable on and off
        clear_mem();
        mem[16'h180 >> 4] = mk(1, 1, 32'h0, 1);
        mem[16'h1A0 >> 4] = mk(7, 0, 32'h0, 0);
        run_chain(32'h180, 1'b1, "R10");
        chk(got_irq && obs_f.size() == 1, "R10", "irq stops chain", {got_irq, 8'(obs_f.size())}, 9'h101);
        run_chain(32'h180, 1'b0, "R10");
        chk(!got_irq && obs_f.size() == 2, "R10", "irq ignored when disabled", {got_irq, 8'(obs_f.size())}, 9'h002);

        // random tag memories: R2 R3 R4 R5 R6 R7 R9 R10 mixed
        for (int r = 0; r < 40; r++) begin
            logic [31:0] s;
            logic        tie;
            ok = 0;
            while (!ok) begin
                for (int i = 0; i < 1024; i++) begin
                    logic [31:0] a;
                    a = ($urandom % 1024) << 4;
                    if ($urandom % 20 == 0) a = a | 32'h8;
                    mem[i] = mk(int'($urandom % 8), int'($urandom % 4), a, ($urandom % 10) == 0);
                end
                s = ($urandom % 1024) << 4;
                if ($urandom % 25 == 0) s = s | 32'h4;
                tie = 1'($urandom % 2);
                model(s, tie, ok);
            end
            run_chain(s, tie, "R2/R3/R4/R5/R6/R7/R9/R10 random");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule